// File: doc/BRIEF.md
# Punched-Card Feed and Column Capture Sequencer

This block sits between a card reader and the channel logic of a host controller. A feed command starts card motion by raising a feed output toward the reader. While the card moves, the reader pulses a strobe once per column. On each strobe the block captures the 12 row bits of that column into a holding register and raises a data-available flag. The host empties the register with a read acknowledge. When the reader reports that the last column has passed, the block drops the feed output and raises an end-of-operation flag.

The block watches for three faults. An overrun occurs when a strobe arrives before the previous column was read. A jam occurs when no strobe follows a feed within a set number of clock cycles. An alarm is raised when the reader's ready line falls. A feed issued while a card is still moving starts continuous feeding. The unread rest of the current card is dropped, its end-of-card pulse is ignored, and capture resumes on the first strobe of the next card. End of operation is then reported only for the last card.

The strobe, end-of-card and ready inputs are brought into the clock domain through two-flop synchronizers, and the block acts on the rising edges of the synchronized signals. The column bits are sampled without synchronization, so the reader must hold them stable while its strobe is high. The sequencer has five states. `ST_IDLE` means no card is moving. `ST_WAIT` means a feed was issued and the first strobe has not yet arrived. `ST_READ` means columns are being captured. `ST_LOCK` means an early feed is waiting for the next card. `ST_JAM` means the feed timed out. The transitions are as follows. A feed moves `ST_IDLE` or `ST_JAM` to `ST_WAIT`, and moves `ST_WAIT`, `ST_READ` or `ST_LOCK` to `ST_LOCK`. A clear without a feed moves any state to `ST_IDLE`. A strobe moves `ST_WAIT` or `ST_LOCK` to `ST_READ`. An end-of-card pulse moves `ST_WAIT` or `ST_READ` to `ST_IDLE` and sets end of operation. A timer expiry moves `ST_WAIT` or `ST_LOCK` to `ST_JAM`.

Top module: `card_capture_seq`

## Requirements
- R1: After reset, `feed_o`, `busy`, `data_avail`, `lost_data`, `eop` and `fail` are 0 and `col_reg` is 0.
- R2: A one-cycle `feed_cmd` makes `feed_o` and `busy` 1 from the next clock edge. Both stay 1 until end of operation, a jam, or a clear.
- R3: A strobe rising edge is acted on at the third clock edge after the input rises. If the data flag is clear and a feed is in progress, `col_reg` takes `col_in` bit for bit, with bit 0 holding card row 9, and `data_avail` becomes 1.
- R4: A one-cycle `read_ack` while `data_avail` is 1 clears `data_avail` at the next edge and leaves `col_reg` unchanged.
- R5: A strobe that arrives while `data_avail` is 1 sets `lost_data`, leaves `col_reg` unchanged, and raises `alarm`.
- R6: While `lost_data` is 1, no strobe changes `col_reg` or `data_avail`. `lost_data` is cleared only by a clear or by a new feed.
- R7: An end-of-card rising edge in `ST_WAIT` or `ST_READ` drops `feed_o` and `busy` and sets `eop`. `eop` is cleared by the next feed or by a clear.
- R8: A feed issued while `busy` is 1 enters `ST_LOCK`. `feed_o` stays 1, an end-of-card pulse there is ignored (`eop` stays 0), and the next strobe is captured and resumes reading.
- R9: If no strobe arrives within `JAM_CYCLES` cycles of a feed, `fail` becomes 1 and `feed_o` and `busy` drop. While `fail` is 1, end-of-card pulses leave `eop` at 0.
- R10: `alarm` is 1 while the synchronized ready input is 0 or while `lost_data` is 1, and is 0 otherwise.
- R11: When `feed_cmd` and `clear_cmd` are both 1 in the same cycle, the feed takes effect and the clear is ignored. `data_avail` is kept and `busy` stays 1.
- R12: A `clear_cmd` without a feed drops `feed_o` and `busy` and clears `data_avail`, `lost_data`, `eop` and `fail`.
- R13: Strobes that arrive in `ST_IDLE` change neither `col_reg` nor `data_avail`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Master clear, active low, asynchronous |
| feed_cmd | input | 1 | One-cycle feed request |
| clear_cmd | input | 1 | One-cycle controller clear |
| read_ack | input | 1 | One-cycle acknowledge that the column was read |
| rdr_ready | input | 1 | Reader ready level (asynchronous) |
| strobe_in | input | 1 | Column strobe from the reader (asynchronous) |
| end_in | input | 1 | End-of-card pulse from the reader (asynchronous) |
| col_in | input | COL_W | Column row bits, bit 0 = row 9 |
| feed_o | output | 1 | Feed drive to the reader |
| col_reg | output | COL_W | Captured column |
| data_avail | output | 1 | Column waiting to be read |
| busy | output | 1 | Feed in progress |
| eop | output | 1 | End of operation |
| lost_data | output | 1 | Overrun occurred |
| fail | output | 1 | Feed timed out without a strobe |
| alarm | output | 1 | Ready lost or overrun |

## Verification
The hardest situation to reach is the continuous-feed lock. It needs a card in flight with an unread column, followed by a feed that coincides with a clear. The stimulus starts a feed and captures one column without reading it. It then pulses feed and clear in the same cycle, and checks that the column flag survives and that busy holds. Next it sends an end-of-card pulse while the block is locked, which must not raise end of operation. Finally it sends a strobe that must be captured as the first column of the next card, followed by an end-of-card pulse that must complete the operation. The jam timeout is reached by shrinking `JAM_CYCLES` and then simply withholding strobes.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WAIT = 3'd1,
        ST_READ = 3'd2,
        ST_LOCK = 3'd3,
        ST_JAM  = 3'd4
    } seq_state_t;
endpackage

// File: rtl/cr_sync.sv
module cr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_in};
    end

    assign q_out = chain[STAGES-1];
endmodule

// File: rtl/cr_rise.sv
module cr_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= lvl;
    end

    assign rise = lvl & ~prev;
endmodule

// File: rtl/cr_jam_timer.sv
module cr_jam_timer #(
    parameter int LIMIT = 2_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (!run)  cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign expire = run && (cnt == LAST);
endmodule

// File: rtl/cr_column_path.sv
module cr_column_path #(
    parameter int COL_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             feed_cmd,
    input  logic             clear_cmd,
    input  logic             read_ack,
    input  logic             strobe_rise,
    input  logic             accept,
    input  logic [COL_W-1:0] col_in,
    output logic [COL_W-1:0] col_reg,
    output logic             data_avail,
    output logic             lost_data
);
    logic take;

    // A strobe counts only while a card is being fed and no overrun blocks it.
    assign take = strobe_rise && accept && !lost_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_reg    <= '0;
            data_avail <= 1'b0;
            lost_data  <= 1'b0;
        end else if (feed_cmd) begin
            // feed outranks clear: only the overrun is forgotten
            lost_data <= 1'b0;
            if (read_ack) data_avail <= 1'b0;
        end else if (clear_cmd) begin
            lost_data  <= 1'b0;
            data_avail <= 1'b0;
        end else begin
            if (take && data_avail) begin
                lost_data <= 1'b1;
                if (read_ack) data_avail <= 1'b0;
            end else if (take) begin
                col_reg    <= col_in;
                data_avail <= 1'b1;
            end else if (read_ack) begin
                data_avail <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cr_feed_fsm.sv
module cr_feed_fsm
    import card_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic feed_cmd,
    input  logic clear_cmd,
    input  logic strobe_rise,
    input  logic end_rise,
    input  logic jam_expire,
    output logic feed_o,
    output logic busy,
    output logic fail,
    output logic eop,
    output logic accept,
    output logic timer_run
);
    seq_state_t state, nxt;
    logic       eop_set;
    logic       moving;

    assign moving = (state == ST_WAIT) || (state == ST_READ) || (state == ST_LOCK);

    // next-state logic
    always_comb begin
        nxt     = state;
        eop_set = 1'b0;
        if (feed_cmd) begin
            nxt = moving ? ST_LOCK : ST_WAIT;
        end else if (clear_cmd) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: nxt = ST_IDLE;
                ST_WAIT: begin
                    if (strobe_rise)     nxt = ST_READ;
                    else if (end_rise) begin
                        nxt     = ST_IDLE;
                        eop_set = 1'b1;
                    end
                    else if (jam_expire) nxt = ST_JAM;
                end
                ST_READ: begin
                    if (end_rise) begin
                        nxt     = ST_IDLE;
                        eop_set = 1'b1;
                    end
                end
                ST_LOCK: begin
                    if (strobe_rise)     nxt = ST_READ;
                    else if (jam_expire) nxt = ST_JAM;
                end
                ST_JAM:  nxt = ST_JAM;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            eop   <= 1'b0;
        end else begin
            state <= nxt;
            if (feed_cmd || clear_cmd) eop <= 1'b0;
            else if (eop_set)          eop <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy      = moving;
        feed_o    = moving;
        fail      = (state == ST_JAM);
        accept    = moving && !feed_cmd && !clear_cmd;
        timer_run = ((state == ST_WAIT) || (state == ST_LOCK)) && !feed_cmd && !clear_cmd;
    end
endmodule

// File: rtl/card_capture_seq.sv
module card_capture_seq #(
    parameter int COL_W       = 12,
    parameter int SYNC_STAGES = 2,
    parameter int JAM_CYCLES  = 2_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             feed_cmd,
    input  logic             clear_cmd,
    input  logic             read_ack,
    input  logic             rdr_ready,
    input  logic             strobe_in,
    input  logic             end_in,
    input  logic [COL_W-1:0] col_in,
    output logic             feed_o,
    output logic [COL_W-1:0] col_reg,
    output logic             data_avail,
    output logic             busy,
    output logic             eop,
    output logic             lost_data,
    output logic             fail,
    output logic             alarm
);
    logic rdy_s, stb_s, end_s;
    logic stb_rise, end_rise;
    logic accept, timer_run, jam_expire;

    cr_sync #(.STAGES(SYNC_STAGES)) u_sync_rdy (.clk(clk), .rst_n(rst_n), .d_in(rdr_ready), .q_out(rdy_s));
    cr_sync #(.STAGES(SYNC_STAGES)) u_sync_stb (.clk(clk), .rst_n(rst_n), .d_in(strobe_in), .q_out(stb_s));
    cr_sync #(.STAGES(SYNC_STAGES)) u_sync_end (.clk(clk), .rst_n(rst_n), .d_in(end_in),    .q_out(end_s));

    cr_rise u_rise_stb (.clk(clk), .rst_n(rst_n), .lvl(stb_s), .rise(stb_rise));
    cr_rise u_rise_end (.clk(clk), .rst_n(rst_n), .lvl(end_s), .rise(end_rise));

    cr_jam_timer #(.LIMIT(JAM_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(timer_run), .expire(jam_expire)
    );

    cr_feed_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .feed_cmd(feed_cmd), .clear_cmd(clear_cmd),
        .strobe_rise(stb_rise), .end_rise(end_rise), .jam_expire(jam_expire),
        .feed_o(feed_o), .busy(busy), .fail(fail), .eop(eop),
        .accept(accept), .timer_run(timer_run)
    );

    cr_column_path #(.COL_W(COL_W)) u_cols (
        .clk(clk), .rst_n(rst_n), .feed_cmd(feed_cmd), .clear_cmd(clear_cmd),
        .read_ack(read_ack), .strobe_rise(stb_rise), .accept(accept),
        .col_in(col_in), .col_reg(col_reg), .data_avail(data_avail),
        .lost_data(lost_data)
    );

    assign alarm = lost_data | ~rdy_s;
endmodule

// File: rtl/card_capture_seq_chk.sv
module card_capture_seq_chk #(
    parameter int COL_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             feed_cmd,
    input logic             clear_cmd,
    input logic             read_ack,
    input logic             feed_o,
    input logic [COL_W-1:0] col_reg,
    input logic             data_avail,
    input logic             busy,
    input logic             eop,
    input logic             lost_data,
    input logic             fail,
    input logic             alarm
);
    p_feed_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        feed_cmd |=> (feed_o && busy));

    p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (read_ack && data_avail) |=> !data_avail);

    p_lost_alarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lost_data |-> alarm);

    p_lost_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_data && !feed_cmd && !clear_cmd) |=> (lost_data && $stable(col_reg)));

    p_eop_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eop |-> (!busy && !feed_o));

    p_jam_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (!feed_o && !eop));

    p_feed_beats_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (feed_cmd && clear_cmd && data_avail && !read_ack) |=> (data_avail && busy));

    p_clear_stops_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_cmd && !feed_cmd) |=> (!feed_o && !data_avail && !lost_data && !eop && !fail));
endmodule

bind card_capture_seq card_capture_seq_chk #(.COL_W(COL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .feed_cmd(feed_cmd), .clear_cmd(clear_cmd),
    .read_ack(read_ack), .feed_o(feed_o), .col_reg(col_reg),
    .data_avail(data_avail), .busy(busy), .eop(eop), .lost_data(lost_data),
    .fail(fail), .alarm(alarm)
);

// File: tb/card_capture_seq_bench.sv
module card_capture_seq_bench;
    localparam int CW  = 12;
    localparam int JAM = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic feed_cmd = 1'b0, clear_cmd = 1'b0, read_ack = 1'b0;
    logic rdr_ready = 1'b1, strobe_in = 1'b0, end_in = 1'b0;
    logic [CW-1:0] col_in = '0;
    logic feed_o, data_avail, busy, eop, lost_data, fail, alarm;
    logic [CW-1:0] col_reg;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    card_capture_seq #(.COL_W(CW), .SYNC_STAGES(2), .JAM_CYCLES(JAM)) u_card_capture_seq (
        .clk(clk), .rst_n(rst_n), .feed_cmd(feed_cmd), .clear_cmd(clear_cmd),
        .read_ack(read_ack), .rdr_ready(rdr_ready), .strobe_in(strobe_in),
        .end_in(end_in), .col_in(col_in), .feed_o(feed_o), .col_reg(col_reg),
        .data_avail(data_avail), .busy(busy), .eop(eop), .lost_data(lost_data),
        .fail(fail), .alarm(alarm)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic f, input logic c, input logic a);
        @(negedge clk);
        feed_cmd = f; clear_cmd = c; read_ack = a;
        @(negedge clk);
        feed_cmd = 1'b0; clear_cmd = 1'b0; read_ack = 1'b0;
    endtask

    task automatic strobe(input logic [CW-1:0] v);
        @(negedge clk);
        col_in = v; strobe_in = 1'b1;
        cyc(4);
        strobe_in = 1'b0;
        cyc(3);
    endtask

    task automatic end_card();
        @(negedge clk);
        end_in = 1'b1;
        cyc(4);
        end_in = 1'b0;
        cyc(3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(4);
        // R1 reset state
        chk("R1 feed_o", feed_o, 0);
        chk("R1 busy", busy, 0);
        chk("R1 data_avail", data_avail, 0);
        chk("R1 lost_data", lost_data, 0);
        chk("R1 eop", eop, 0);
        chk("R1 fail", fail, 0);
        chk("R1 col_reg", col_reg, 0);
        chk("R10 alarm clear with ready", alarm, 0);

        // R13 strobe while idle is ignored
        strobe(12'hABC);
        chk("R13 col_reg", col_reg, 0);
        chk("R13 data_avail", data_avail, 0);

        // R2 feed
        pulse(1, 0, 0);
        chk("R2 feed_o", feed_o, 1);
        chk("R2 busy", busy, 1);

        // R3/R4 walking-one sweep over every row bit, bit 0 = row 9
        for (int b = 0; b < CW; b++) begin
            strobe(CW'(1) << b);
            chk("R3 walk col_reg", col_reg, 32'(CW'(1) << b));
            chk("R3 walk data_avail", data_avail, 1);
            pulse(0, 0, 1);
            chk("R4 ack clears", data_avail, 0);
            chk("R4 col kept", col_reg, 32'(CW'(1) << b));
        end
        // R3 arithmetic patterns
        for (int i = 0; i < 8; i++) begin
            logic [CW-1:0] p;
            p = CW'((i * 1307 + 91) ^ (i << 7));
            strobe(p);
            chk("R3 pattern", col_reg, 32'(p));
            pulse(0, 0, 1);
        end
        chk("R2 busy during card", busy, 1);

        // R5 overrun
        strobe(12'h5A5);
        strobe(12'h3C3);
        chk("R5 lost_data", lost_data, 1);
        chk("R5 col kept", col_reg, 32'h5A5);
        chk("R5 alarm", alarm, 1);
        // R6 no capture after overrun
        pulse(0, 0, 1);
        strobe(12'h0F0);
        chk("R6 col kept", col_reg, 32'h5A5);
        chk("R6 data_avail", data_avail, 0);
        chk("R6 lost held", lost_data, 1);
        // R12 clear
        pulse(0, 1, 0);
        chk("R12 lost cleared", lost_data, 0);
        chk("R12 feed_o", feed_o, 0);
        chk("R12 busy", busy, 0);
        chk("R10 alarm follows lost", alarm, 0);

        // R7 normal end of card, R6 feed clears lost
        pulse(1, 0, 0);
        strobe(12'h111);
        strobe(12'h222);
        chk("R6 lost before feed", lost_data, 1);
        end_card();
        chk("R7 eop", eop, 1);
        chk("R7 feed_o", feed_o, 0);
        chk("R7 busy", busy, 0);
        pulse(1, 0, 0);
        chk("R6 feed clears lost", lost_data, 0);
        chk("R7 feed clears eop", eop, 0);

        // R11 feed + clear together, then R8 lock
        strobe(12'h777);
        pulse(1, 1, 0);
        chk("R11 data kept", data_avail, 1);
        chk("R11 busy", busy, 1);
        pulse(0, 0, 1);
        end_card();
        chk("R8 end ignored eop", eop, 0);
        chk("R8 end ignored busy", busy, 1);
        strobe(12'h9E1);
        chk("R8 next card captured", col_reg, 32'h9E1);
        chk("R8 data_avail", data_avail, 1);
        pulse(0, 0, 1);
        end_card();
        chk("R8 last card eop", eop, 1);
        chk("R8 feed_o dropped", feed_o, 0);

        // R9 jam
        pulse(1, 0, 0);
        cyc(JAM - 10);
        chk("R9 not yet failed", fail, 0);
        cyc(15);
        chk("R9 fail", fail, 1);
        chk("R9 feed_o", feed_o, 0);
        chk("R9 busy", busy, 0);
        end_card();
        chk("R9 eop inhibited", eop, 0);
        pulse(0, 1, 0);
        chk("R12 fail cleared", fail, 0);

        // R10 ready loss
        @(negedge clk);
        rdr_ready = 1'b0;
        cyc(3);
        chk("R10 alarm on not ready", alarm, 1);
        rdr_ready = 1'b1;
        cyc(3);
        chk("R10 alarm released", alarm, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule